// File: doc/BRIEF.md
# Breakpoint Acknowledge Controller

This block sits next to a pipelined CPU front end and turns an external breakpoint request into a breakpoint exception. Each time the front end latches a fetched word, the block samples the breakpoint input on the same clock edge. If both are valid, it marks the word as tagged. The tag follows the word down the pipeline. A tag from an instruction prefetch belongs to the instruction that was fetched. A tag from an operand fetch belongs to the instruction that is executing now.

When the owning instruction completes and debug mode is off, the block starts a fixed read in CPU space that acknowledges the breakpoint. The read is word-sized, uses function code 111 and address 0x00001E. When a normal acknowledge or a bus error ends that read, the block pulses an exception request. When debug mode is on, the block issues no bus cycle and pulses a debug-entry output instead. A pipeline flush discards every pending tag.

Top module: `bkpt_ack_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bus_req_o`, `exc_req_o` and `dbg_entry_o` are low and no tag is pending.
- R2: A tag is captured only at a clock edge where `brk_i` and `fetch_vld_i` are both high. A breakpoint request without a fetch strobe leads to no bus cycle.
- R3: A tag captured with `fetch_operand_i`=0 (prefetch) starts the acknowledge after the second later `insn_done_i` edge. `bus_req_o` is high in the cycle after that edge and stays low after the first one.
- R4: A tag captured with `fetch_operand_i`=1 (operand fetch) starts the acknowledge in the cycle after the next `insn_done_i` edge.
- R5: A `flush_i` edge clears all pending tags. A later `insn_done_i` then produces no bus request and no debug-entry pulse.
- R6: While `bus_req_o` is high, the outputs hold these values: `bus_addr_o`=0x00001E, `bus_fc_o`=3'b111, `bus_rd_o`=1 and `bus_word_o`=1. In the address, bits 19:16 (cycle type) are 0000, bits 4:2 (breakpoint number) are 111 and bit 1 (type bit) is 1.
- R7: `bus_req_o` and `bus_addr_o` stay stable until a termination edge (`bus_ack_i` or `bus_err_i` high). `bus_req_o` is low in the cycle after that edge.
- R8: After termination by either `bus_ack_i` or `bus_err_i`, `exc_req_o` is high for exactly one cycle, the cycle right after the terminating edge.
- R9: With `dbg_en_i`=1, a completing tagged instruction raises `dbg_entry_o` for one cycle in place of a bus cycle. `bus_req_o` stays low.
- R10: Fetch tags that arrive while an acknowledge is in progress (bus cycle or exception pulse) are ignored. A later `insn_done_i` produces no new acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_i | input | 1 | External breakpoint request |
| fetch_vld_i | input | 1 | Fetched data word is valid this cycle |
| fetch_operand_i | input | 1 | Kind of fetch: 0 = prefetch, 1 = operand |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| flush_i | input | 1 | Pipeline flush |
| dbg_en_i | input | 1 | Debug mode enabled |
| bus_ack_i | input | 1 | Normal termination of the bus cycle |
| bus_err_i | input | 1 | Bus error termination |
| bus_req_o | output | 1 | Acknowledge bus cycle request |
| bus_addr_o | output | ADDR_W (24) | Bus address |
| bus_fc_o | output | FC_W (3) | Function code |
| bus_rd_o | output | 1 | Read strobe |
| bus_word_o | output | 1 | Word-size select |
| exc_req_o | output | 1 | Breakpoint exception request pulse |
| dbg_entry_o | output | 1 | Debug-entry pulse |

## Verification
The bench tags a word through an operand fetch and through a prefetch. This shows whether the acknowledge waits for one instruction completion or for two. It ends the cycle once with a normal acknowledge and once with a bus error, to show that both paths raise the exception. Patterns with a breakpoint but no fetch strobe, with a flush between the tag and completion, and with debug mode on confirm that no bus cycle comes out where none is due. A tag offered in the middle of a running acknowledge shows whether the block stays blind to it.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_EXC  = 2'd2
    } ack_st_e;

    localparam logic [2:0] FC_CPU_SPACE  = 3'b111;
    localparam logic [3:0] CS_TYPE_BRK   = 4'b0000;
    localparam logic [2:0] BRK_NUMBER    = 3'b111;
    localparam logic       BRK_TYPE_BIT  = 1'b1;

    // low 20 address bits: type[19:16], zeros[15:5], number[4:2], T[1], 0
    localparam logic [19:0] ACK_ADDR_LO =
        {CS_TYPE_BRK, 11'b0, BRK_NUMBER, BRK_TYPE_BIT, 1'b0};

endpackage

// File: rtl/bkpt_tag_track.sv
module bkpt_tag_track (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic fetch_vld_i,
    input  logic fetch_operand_i,
    input  logic insn_done_i,
    input  logic flush_i,
    input  logic busy_i,
    output logic fire_o
);

    typedef struct packed {
        logic pf;   // tag bound to the prefetched (next) instruction
        logic cur;  // tag bound to the executing instruction
    } tag_s;

    tag_s s_d, s_q;
    logic capture;
    logic pf_new, cur_new;

    always_comb begin
        s_d     = s_q;
        fire_o  = 1'b0;
        capture = brk_i & fetch_vld_i & ~busy_i;
        pf_new  = s_q.pf  | (capture & ~fetch_operand_i);
        cur_new = s_q.cur | (capture &  fetch_operand_i);
        if (flush_i) begin
            s_d = '0;
        end else if (busy_i) begin
            s_d = s_q;
        end else if (insn_done_i) begin
            fire_o = cur_new;
            s_d.cur = pf_new;
            s_d.pf  = 1'b0;
        end else begin
            s_d.pf  = pf_new;
            s_d.cur = cur_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bkpt_ack_fsm.sv
module bkpt_ack_fsm
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              dbg_en_i,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    output logic              busy_o,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [FC_W-1:0]   bus_fc_o,
    output logic              bus_rd_o,
    output logic              bus_word_o,
    output logic              exc_req_o,
    output logic              dbg_entry_o
);

    localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(ACK_ADDR_LO);
    localparam logic [FC_W-1:0]   ACK_FC   = FC_W'(FC_CPU_SPACE);

    typedef struct packed {
        ack_st_e st;
        logic    dbg;
    } fsm_s;

    fsm_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.dbg = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (fire_i) begin
                    if (dbg_en_i) s_d.dbg = 1'b1;
                    else          s_d.st  = ST_ACK;
                end
            end
            ST_ACK: begin
                if (bus_ack_i || bus_err_i) s_d.st = ST_EXC;
            end
            ST_EXC:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, dbg: 1'b0};
        else        s_q <= s_d;
    end

    assign busy_o      = (s_q.st != ST_IDLE);
    assign bus_req_o   = (s_q.st == ST_ACK);
    assign bus_addr_o  = bus_req_o ? ACK_ADDR : '0;
    assign bus_fc_o    = bus_req_o ? ACK_FC   : '0;
    assign bus_rd_o    = bus_req_o;
    assign bus_word_o  = bus_req_o;
    assign exc_req_o   = (s_q.st == ST_EXC);
    assign dbg_entry_o = s_q.dbg;

endmodule

// File: rtl/bkpt_ack_ctrl.sv
module bkpt_ack_ctrl #(
    parameter int ADDR_W = 24,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_i,
    input  logic              fetch_vld_i,
    input  logic              fetch_operand_i,
    input  logic              insn_done_i,
    input  logic              flush_i,
    input  logic              dbg_en_i,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [FC_W-1:0]   bus_fc_o,
    output logic              bus_rd_o,
    output logic              bus_word_o,
    output logic              exc_req_o,
    output logic              dbg_entry_o
);

    logic fire;
    logic busy;

    bkpt_tag_track tag_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .brk_i           (brk_i),
        .fetch_vld_i     (fetch_vld_i),
        .fetch_operand_i (fetch_operand_i),
        .insn_done_i     (insn_done_i),
        .flush_i         (flush_i),
        .busy_i          (busy),
        .fire_o          (fire)
    );

    bkpt_ack_fsm #(
        .ADDR_W (ADDR_W),
        .FC_W   (FC_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .dbg_en_i    (dbg_en_i),
        .bus_ack_i   (bus_ack_i),
        .bus_err_i   (bus_err_i),
        .busy_o      (busy),
        .bus_req_o   (bus_req_o),
        .bus_addr_o  (bus_addr_o),
        .bus_fc_o    (bus_fc_o),
        .bus_rd_o    (bus_rd_o),
        .bus_word_o  (bus_word_o),
        .exc_req_o   (exc_req_o),
        .dbg_entry_o (dbg_entry_o)
    );

endmodule

// File: rtl/bkpt_ack_ctrl_chk.sv
module bkpt_ack_ctrl_chk #(
    parameter int ADDR_W = 24,
    parameter int FC_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ack_i,
    input logic              bus_err_i,
    input logic              bus_req_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [FC_W-1:0]   bus_fc_o,
    input logic              bus_rd_o,
    input logic              bus_word_o,
    input logic              exc_req_o,
    input logic              dbg_entry_o
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!bus_req_o && !exc_req_o && !dbg_entry_o));

    p_ack_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> (bus_addr_o == ADDR_W'(24'h00001E) && bus_fc_o == FC_W'(3'b111)
                       && bus_rd_o && bus_word_o));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i && !bus_err_i) |=> (bus_req_o && $stable(bus_addr_o)));

    p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && (bus_ack_i || bus_err_i)) |=> (!bus_req_o && exc_req_o));

    p_exc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |=> !exc_req_o);

    p_exc_after_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exc_req_o) |-> $past(bus_req_o));

    p_dbg_no_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_entry_o |-> (!bus_req_o && !exc_req_o));

endmodule

bind bkpt_ack_ctrl bkpt_ack_ctrl_chk #(.ADDR_W(ADDR_W), .FC_W(FC_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ack_i   (bus_ack_i),
    .bus_err_i   (bus_err_i),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_fc_o    (bus_fc_o),
    .bus_rd_o    (bus_rd_o),
    .bus_word_o  (bus_word_o),
    .exc_req_o   (exc_req_o),
    .dbg_entry_o (dbg_entry_o)
);

// File: tb/bkpt_ack_ctrl_tb_top.sv
`timescale 1ns/1ps
module bkpt_ack_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        brk_i = 1'b0, fetch_vld_i = 1'b0, fetch_operand_i = 1'b0;
    logic        insn_done_i = 1'b0, flush_i = 1'b0, dbg_en_i = 1'b0;
    logic        bus_ack_i = 1'b0, bus_err_i = 1'b0;
    logic        bus_req_o, bus_rd_o, bus_word_o, exc_req_o, dbg_entry_o;
    logic [23:0] bus_addr_o;
    logic [2:0]  bus_fc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bkpt_ack_ctrl dut_i (.*);

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tag_word(input logic operand);
        brk_i = 1'b1; fetch_vld_i = 1'b1; fetch_operand_i = operand;
        tick();
        brk_i = 1'b0; fetch_vld_i = 1'b0; fetch_operand_i = 1'b0;
    endtask

    task automatic complete();
        insn_done_i = 1'b1;
        tick();
        insn_done_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 bus_req in reset", 32'(bus_req_o), 0);
        chk("R1 exc_req in reset", 32'(exc_req_o), 0);
        chk("R1 dbg_entry in reset", 32'(dbg_entry_o), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 bus_req after reset", 32'(bus_req_o), 0);
        complete();
        chk("R1 no tag pending after reset", 32'(bus_req_o), 0);
    endtask

    task automatic t_operand();
        tag_word(1'b1);
        chk("R4 no req before completion", 32'(bus_req_o), 0);
        complete();
        chk("R4 req after completion", 32'(bus_req_o), 1);
        chk("R6 address", 32'(bus_addr_o), 32'h1E);
        chk("R6 function code", 32'(bus_fc_o), 7);
        chk("R6 read", 32'(bus_rd_o), 1);
        chk("R6 word", 32'(bus_word_o), 1);
        tick(); tick();
        chk("R7 req held", 32'(bus_req_o), 1);
        chk("R7 address held", 32'(bus_addr_o), 32'h1E);
        bus_ack_i = 1'b1;
        tick();
        bus_ack_i = 1'b0;
        chk("R7 req dropped", 32'(bus_req_o), 0);
        chk("R8 exc after ack", 32'(exc_req_o), 1);
        tick();
        chk("R8 exc single cycle", 32'(exc_req_o), 0);
    endtask

    task automatic t_prefetch();
        tag_word(1'b0);
        complete();
        chk("R3 no req after first completion", 32'(bus_req_o), 0);
        tick();
        chk("R3 still idle", 32'(bus_req_o), 0);
        complete();
        chk("R3 req after second completion", 32'(bus_req_o), 1);
        bus_err_i = 1'b1;
        tick();
        bus_err_i = 1'b0;
        chk("R8 req dropped on error", 32'(bus_req_o), 0);
        chk("R8 exc after bus error", 32'(exc_req_o), 1);
        tick();
        chk("R8 exc cleared", 32'(exc_req_o), 0);
    endtask

    task automatic t_no_fetch();
        brk_i = 1'b1;
        tick();
        complete();
        complete();
        brk_i = 1'b0;
        chk("R2 breakpoint without fetch", 32'(bus_req_o), 0);
        fetch_vld_i = 1'b1; fetch_operand_i = 1'b1;
        tick();
        fetch_vld_i = 1'b0; fetch_operand_i = 1'b0;
        complete();
        chk("R2 fetch without breakpoint", 32'(bus_req_o), 0);
    endtask

    task automatic t_flush();
        tag_word(1'b1);
        flush_i = 1'b1;
        tick();
        flush_i = 1'b0;
        complete();
        chk("R5 operand tag flushed", 32'(bus_req_o), 0);
        chk("R5 no debug entry", 32'(dbg_entry_o), 0);
        tag_word(1'b0);
        flush_i = 1'b1;
        tick();
        flush_i = 1'b0;
        complete();
        complete();
        chk("R5 prefetch tag flushed", 32'(bus_req_o), 0);
    endtask

    task automatic t_debug();
        dbg_en_i = 1'b1;
        tag_word(1'b1);
        complete();
        chk("R9 debug entry pulse", 32'(dbg_entry_o), 1);
        chk("R9 no bus req", 32'(bus_req_o), 0);
        tick();
        chk("R9 pulse single cycle", 32'(dbg_entry_o), 0);
        chk("R9 still no bus req", 32'(bus_req_o), 0);
        dbg_en_i = 1'b0;
    endtask

    task automatic t_busy();
        tag_word(1'b1);
        complete();
        chk("R10 ack started", 32'(bus_req_o), 1);
        brk_i = 1'b1; fetch_vld_i = 1'b1; fetch_operand_i = 1'b1; insn_done_i = 1'b1;
        tick();
        brk_i = 1'b0; fetch_vld_i = 1'b0; fetch_operand_i = 1'b0; insn_done_i = 1'b0;
        bus_ack_i = 1'b1;
        tick();
        bus_ack_i = 1'b0;
        brk_i = 1'b1; fetch_vld_i = 1'b1; fetch_operand_i = 1'b0;
        tick();
        brk_i = 1'b0; fetch_vld_i = 1'b0;
        complete();
        chk("R10 tag during busy ignored", 32'(bus_req_o), 0);
        complete();
        chk("R10 no late acknowledge", 32'(bus_req_o), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        tick(); tick();
        t_reset();
        t_operand();
        t_prefetch();
        t_no_fetch();
        t_flush();
        t_debug();
        t_busy();
        tick();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule